// File: doc/BRIEF.md
# Shared General-Purpose I/O Port with Peripheral Takeover

This block is a 16-pin general-purpose I/O port on a processor data bus. A direction register and an output data latch set up each pin. A direction bit of 1 makes the pin an input with its driver off. A direction bit of 0 makes it an output that drives the latch value. Any pin can be taken over by an on-chip peripheral through a per-pin enable. While the enable is set, the peripheral's own output-enable and output-data go to the pad in place of the port's registers.

The pad input is sampled into a one-stage register on every clock. That register feeds both the bus read of the pin state and the input-data bus to the peripherals. The peripherals always see it, whatever their enable. Because of this register, a pin read returns the new level only one cycle after the write or direction change that caused it. A per-pin analog mask forces the pin read to zero. It does not change what the pin drives.

The bus has three register views, chosen by a 2-bit address. Writes have one byte enable per 8-bit lane. Reads are combinational from the current address.

Top module: `shared_gpio_port`

## Requirements
- R1: After reset every direction bit is 1, the output latch is 0, and with no peripheral enable set every padOe bit is 0.
- R2: With periphEn[i]=0, padOe[i] is the inverse of direction bit i, and padOut[i] equals latch bit i.
- R3: A write to address 1 or to address 2 updates the same output latch.
- R4: busByteEn[k] gates bits 8k+7..8k of a write. Lanes whose enable is 0 keep their old value, in both the direction register and the latch.
- R5: A read at address 0 returns the direction register, and a read at address 1 returns the stored latch value, not the pad level. A read at address 2 returns the sampled pin state.
- R6: At address 2, every bit with anaCfg[i]=1 reads 0. anaCfg has no effect on padOe or padOut.
- R7: With periphEn[i]=1, padOe[i]=periphOe[i] and padOut[i]=periphOut[i], whatever the direction and latch bits.
- R8: The pad input is registered once. A pin read in the cycle right after a latch or direction write still shows the old level, and the new level appears one cycle later.
- R9: periphIn carries the registered pad input for every pin, whether or not periphEn is set.
- R10: Writes to address 3 change no state, and a read at address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register select: 0 direction, 1 latch, 2 port, 3 unused |
| busWrEn | input | 1 | Write strobe |
| busByteEn | input | 2 | Per-lane write enables |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Combinational read data for busAddr |
| anaCfg | input | 16 | Per-pin analog mask for port reads |
| periphEn | input | 16 | Per-pin peripheral takeover |
| periphOe | input | 16 | Peripheral output enables |
| periphOut | input | 16 | Peripheral output data |
| periphIn | output | 16 | Registered pad input for peripherals |
| padIn | input | 16 | Pad input level |
| padOe | output | 16 | Pad driver enable |
| padOut | output | 16 | Pad output data |

## Verification
On every cycle, the assertions check four things. The peripheral takeover holds on every enabled pin. periphIn follows padIn with a one-cycle lag. A port read equals the sampled input with the analog pins cleared. The unused address reads zero. Other behaviours can only be shown by the bench's scenarios, with a loopback pad model and a tracked register state: the reset values, the byte-lane masking, the shared latch behind two addresses, the latch read differing from the pad level, and the old value returned right after a write.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Register addresses on the bus.
  localparam logic [1:0] ADDR_DIR  = 2'd0;
  localparam logic [1:0] ADDR_LAT  = 2'd1;
  localparam logic [1:0] ADDR_PORT = 2'd2;

  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_PIN  = 2'd2,
    SEL_NONE = 2'd3
  } rdSel_e;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic   wrDir;
    logic   wrLat;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  output ctrlStrobe_t strobe
);

  always_comb begin
    strobe.wrDir = 1'b0;
    strobe.wrLat = 1'b0;
    strobe.rdSel = SEL_NONE;
    unique case (busAddr)
      ADDR_DIR: begin
        strobe.wrDir = busWrEn;
        strobe.rdSel = SEL_DIR;
      end
      ADDR_LAT: begin
        strobe.wrLat = busWrEn;
        strobe.rdSel = SEL_LAT;
      end
      ADDR_PORT: begin
        // Writes to the port view land in the same latch.
        strobe.wrLat = busWrEn;
        strobe.rdSel = SEL_PIN;
      end
      default: begin
        strobe.wrDir = 1'b0;
        strobe.wrLat = 1'b0;
        strobe.rdSel = SEL_NONE;
      end
    endcase
  end

endmodule

// File: rtl/gpio_port_datapath.sv
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int LANE_W = 8,
  parameter int N_LANE = PINS / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [N_LANE-1:0] busByteEn,
  input  logic [PINS-1:0]   busWrData,
  input  logic [PINS-1:0]   anaCfg,
  input  logic [PINS-1:0]   periphEn,
  input  logic [PINS-1:0]   periphOe,
  input  logic [PINS-1:0]   periphOut,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   busRdData,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   periphIn
);

  logic [PINS-1:0] dirQ;
  logic [PINS-1:0] latQ;
  logic [PINS-1:0] pinQ;
  logic [PINS-1:0] laneMask;

  // Byte enables widened to a per-bit write mask.
  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    assign laneMask[g*LANE_W +: LANE_W] = {LANE_W{busByteEn[g]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ <= '1;
    end else if (strobe.wrDir) begin
      dirQ <= (dirQ & ~laneMask) | (busWrData & laneMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latQ <= '0;
    end else if (strobe.wrLat) begin
      latQ <= (latQ & ~laneMask) | (busWrData & laneMask);
    end
  end

  // One-stage input register: the source of the one-cycle read lag.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ <= '0;
    end else begin
      pinQ <= padIn;
    end
  end

  // Per-pin output multiplexer: peripheral or port registers.
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_comb begin
      if (periphEn[p]) begin
        padOe[p]  = periphOe[p];
        padOut[p] = periphOut[p];
      end else begin
        padOe[p]  = ~dirQ[p];
        padOut[p] = latQ[p];
      end
    end
  end

  assign periphIn = pinQ;

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DIR:  busRdData = dirQ;
      SEL_LAT:  busRdData = latQ;
      SEL_PIN:  busRdData = pinQ & ~anaCfg;
      default:  busRdData = '0;
    endcase
  end

endmodule

// File: rtl/shared_gpio_port.sv
module shared_gpio_port
  import gpio_port_pkg::*;
#(
  parameter  int PINS   = 16,
  parameter  int LANE_W = 8,
  localparam int N_LANE = PINS / LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [N_LANE-1:0] busByteEn,
  input  logic [PINS-1:0]   busWrData,
  output logic [PINS-1:0]   busRdData,
  input  logic [PINS-1:0]   anaCfg,
  input  logic [PINS-1:0]   periphEn,
  input  logic [PINS-1:0]   periphOe,
  input  logic [PINS-1:0]   periphOut,
  output logic [PINS-1:0]   periphIn,
  input  logic [PINS-1:0]   padIn,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padOut
);

  ctrlStrobe_t strobe;

  gpio_port_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_port_datapath #(
    .PINS   (PINS),
    .LANE_W (LANE_W),
    .N_LANE (N_LANE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busByteEn (busByteEn),
    .busWrData (busWrData),
    .anaCfg    (anaCfg),
    .periphEn  (periphEn),
    .periphOe  (periphOe),
    .periphOut (periphOut),
    .padIn     (padIn),
    .busRdData (busRdData),
    .padOe     (padOe),
    .padOut    (padOut),
    .periphIn  (periphIn)
  );

endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int PINS = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic [1:0]      busAddr,
  input logic [PINS-1:0] busRdData,
  input logic [PINS-1:0] anaCfg,
  input logic [PINS-1:0] periphEn,
  input logic [PINS-1:0] periphOe,
  input logic [PINS-1:0] periphOut,
  input logic [PINS-1:0] periphIn,
  input logic [PINS-1:0] padIn,
  input logic [PINS-1:0] padOe,
  input logic [PINS-1:0] padOut
);

  // R7: enabled pins follow the peripheral.
  p_override_oe_r7: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & periphEn) == (periphOe & periphEn));

  p_override_out_r7: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & periphEn) == (periphOut & periphEn));

  // R8, R9: the peripheral input is the pad level one clock late.
  p_sync_lag_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> periphIn == $past(padIn));

  // R5, R6: the port view is the sampled input with the analog pins cleared.
  p_port_view_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd2) |-> busRdData == (periphIn & ~anaCfg));

  // R10: the unused address reads zero.
  p_unused_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd3) |-> busRdData == '0);

endmodule

bind shared_gpio_port gpio_port_checker #(.PINS(PINS)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .anaCfg    (anaCfg),
  .periphEn  (periphEn),
  .periphOe  (periphOe),
  .periphOut (periphOut),
  .periphIn  (periphIn),
  .padIn     (padIn),
  .padOe     (padOe),
  .padOut    (padOut)
);

// File: tb/tb_shared_gpio_port.sv
`timescale 1ns/1ps
module tb_shared_gpio_port;

  logic        clk = 1'b0;
  logic        rstN;
  logic [1:0]  busAddr;
  logic        busWrEn;
  logic [1:0]  busByteEn;
  logic [15:0] busWrData;
  logic [15:0] busRdData;
  logic [15:0] anaCfg, periphEn, periphOe, periphOut, periphIn;
  logic [15:0] padIn, padOe, padOut;
  logic [15:0] extLevel;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  // Loopback pad: driven pins see their own output, the rest see extLevel.
  assign padIn = (padOe & padOut) | (~padOe & extLevel);

  shared_gpio_port dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busByteEn(busByteEn), .busWrData(busWrData), .busRdData(busRdData),
    .anaCfg(anaCfg), .periphEn(periphEn), .periphOe(periphOe),
    .periphOut(periphOut), .periphIn(periphIn), .padIn(padIn),
    .padOe(padOe), .padOut(padOut)
  );

  function automatic logic [15:0] pinOf(input logic [15:0] oe, input logic [15:0] o,
                                        input logic [15:0] ext);
    return (oe & o) | (~oe & ext);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    busAddr = a; busWrData = d; busByteEn = be; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [1:0] a, input logic [15:0] exp, input string tag);
    busAddr = a;
    #1;
    check(tag, busRdData, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [15:0] dirE, latE, anaE, prevPin, newPin, pe, poe, pout, oeE, outE;
    rstN = 1'b0; busAddr = 2'd0; busWrEn = 1'b0; busByteEn = 2'b11; busWrData = '0;
    anaCfg = '0; periphEn = '0; periphOe = '0; periphOut = '0; extLevel = 16'hC35A;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readCheck(2'd0, 16'hFFFF, "R1 direction reset");
    readCheck(2'd1, 16'h0000, "R1 latch reset");
    check("R1 padOe reset", padOe, 16'h0000);

    // R4 byte lanes, R3 shared latch
    busWrite(2'd0, 16'h1234, 2'b01);
    readCheck(2'd0, 16'hFF34, "R4 dir low lane only");
    busWrite(2'd0, 16'hAB00, 2'b10);
    readCheck(2'd0, 16'hAB34, "R4 dir high lane only");
    busWrite(2'd1, 16'hBEEF, 2'b10);
    readCheck(2'd1, 16'hBE00, "R4 latch high lane only");
    busWrite(2'd2, 16'h00CD, 2'b01);
    readCheck(2'd1, 16'hBECD, "R3 port addr writes latch low lane");
    dirE = 16'hAB34; latE = 16'hBECD;

    // Sweep: direction, latch, analog mask, external level
    for (int i = 0; i < 32; i++) begin
      logic [15:0] nd, nl;
      nd = 16'(i * 16'h3B1D) ^ 16'h5A5A;
      nl = 16'(i * 16'h7E13 + 16'h0101);
      anaE = 16'(i * 16'h1111);
      @(negedge clk);
      anaCfg = anaE;
      extLevel = ~nl ^ 16'(i << 3);
      busWrite(2'd0, nd, 2'b11);
      dirE = nd;
      @(negedge clk);
      prevPin = pinOf(~dirE, latE, extLevel);
      busWrite((i % 2 == 0) ? 2'd1 : 2'd2, nl, 2'b11);
      latE = nl;
      newPin = pinOf(~dirE, latE, extLevel);
      readCheck(2'd2, prevPin & ~anaE, "R8 port read right after write is old");
      readCheck(2'd1, latE, "R3 R5 latch read is stored value");
      readCheck(2'd0, dirE, "R5 direction read");
      check("R2 padOe from direction", padOe, ~dirE);
      check("R2 R6 padOut from latch", padOut, latE);
      @(negedge clk);
      readCheck(2'd2, newPin & ~anaE, "R5 R6 R8 port read one cycle later");
      check("R9 periphIn", periphIn, newPin);
    end

    // Peripheral takeover
    for (int j = 0; j < 8; j++) begin
      pe = 16'(j * 16'h2469) ^ 16'hF0F0;
      poe = 16'(j * 16'h1357) ^ 16'h3C3C;
      pout = 16'(j * 16'h0F1E) ^ 16'h5555;
      @(negedge clk);
      periphEn = pe; periphOe = poe; periphOut = pout;
      #1;
      oeE = (pe & poe) | (~pe & ~dirE);
      outE = (pe & pout) | (~pe & latE);
      check("R7 padOe takeover", padOe, oeE);
      check("R7 padOut takeover", padOut, outE);
      @(negedge clk);
      check("R9 periphIn with takeover", periphIn, pinOf(oeE, outE, extLevel));
      readCheck(2'd2, pinOf(oeE, outE, extLevel) & ~anaE, "R5 R6 port read with takeover");
    end
    @(negedge clk);
    periphEn = '0;

    // R10 unused address
    busWrite(2'd3, 16'h1111, 2'b11);
    readCheck(2'd0, dirE, "R10 direction unchanged");
    readCheck(2'd1, latE, "R10 latch unchanged");
    readCheck(2'd3, 16'h0000, "R10 unused address reads zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule